// File: doc/BRIEF.md
# SPI Receive FIFO with Half-Word Packing

This block is the receive-side queue of a serial peripheral interface that handles short data frames of 4 to 8 bits. The shifter presents each finished frame on a one-cycle strobe, and the frame is stored as one byte entry, right-aligned with the unused upper bits at zero. The host reads through a bus port in one of two widths. A byte read removes the oldest frame. A packed half-word read removes two frames at once: the older one in the low byte and the newer one in the high byte. The read data is combinational from the head of the queue and the width select, and the pop happens at the clock edge where the read strobe is high.

A data-ready flag tells the host when a read is worth doing. Its threshold is one frame in byte mode and two frames in packed mode. The flag is derived from a fill-class state machine with four states: EMPTY (no entries), SINGLE (one entry), PAIR (two or more entries but not full) and FULL (all entries used). The state is recomputed every cycle from the next level, so it can take any of these steps: GO_EMPTY, GO_SINGLE, GO_PAIR, GO_FULL, or HOLD when the class does not change. A packed read can jump from PAIR straight to SINGLE or to EMPTY. After that jump the flag drops at once if fewer than two frames remain, so a second packed request is never raised for a single frame.

A frame that arrives when no room is left, after counting any entries popped in the same cycle, is dropped. It sets a sticky overrun flag that software clears.

Top module: `spi_rx_pack_fifo`

## Requirements
- R1: After reset the level is 0, the ready flag and overrun flag are 0, and `rd_data` reads 16'h0000.
- R2: Frames are kept in arrival order. While `rd_half` is 0, `rd_data[7:0]` shows the oldest frame and `rd_data[15:8]` is 0. A cycle with `rd_en`=1 removes exactly one frame, and short frames come back with the same value they were written with.
- R3: While `rd_half` is 1 and at least two frames are stored, `rd_data[7:0]` is the older frame and `rd_data[15:8]` is the next frame. A cycle with `rd_en`=1 removes both frames.
- R4: `level` counts the stored entries, from 0 up to DEPTH. With the default depth of 4, each step is one quarter of the queue.
- R5: With `thresh16`=0, the ready flag is 1 exactly when the level is at least 1.
- R6: With `thresh16`=1, the ready flag is 1 exactly when the level is at least 2. A packed read from level 3 leaves level 1 with the flag at 0.
- R7: A packed read with only one frame stored returns that frame in the low byte and 0 in the high byte, and it removes only that frame. A read when the queue is empty returns 0 and leaves the level at 0.
- R8: A write and a read in the same cycle change the level by the net count. If the read frees an entry in a full queue, the incoming frame is stored.
- R9: A frame that finds no free entry, after counting the same-cycle pops, is discarded, the level stays at DEPTH, and the overrun flag is set. The discarded frame never shows up in later reads.
- R10: The overrun flag stays at 1 until `ovr_clr` is pulsed. If a new overrun happens in the same cycle as a clear, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | One-cycle strobe from the shifter: a frame is complete |
| wr_data | input | 8 | Received frame, right-aligned |
| rd_en | input | 1 | Host read strobe; pops at the clock edge |
| rd_half | input | 1 | 1 selects a packed half-word read, 0 selects a byte read |
| thresh16 | input | 1 | Ready threshold: 1 means two frames, 0 means one frame |
| ovr_clr | input | 1 | Clears the overrun flag |
| rd_data | output | 16 | Read data: head frame in the low byte, next frame in the high byte for packed reads |
| rxne | output | 1 | Data-ready flag |
| ovr | output | 1 | Sticky overrun flag |
| level | output | 3 | Number of stored entries |

## Verification
The properties assume that `rd_half` and `thresh16` are held steady for the whole cycle around each edge. They also assume that `wr_valid` lasts one cycle per frame, and that a read is only meaningful with `rd_en` as a single-cycle strobe. The stimulus changes every input only at the falling clock edge. Each table row stands for one bus cycle. Frames are right-aligned values whose top bits are zero for short frame sizes. The runs that force overruns keep writing into a full queue both with and without a same-cycle read. This exercises the drop case and the net-count case under the same assumptions.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
    typedef enum logic [1:0] {
        FILL_EMPTY  = 2'd0,
        FILL_SINGLE = 2'd1,
        FILL_PAIR   = 2'd2,
        FILL_FULL   = 2'd3
    } fill_e;
endpackage

// File: rtl/rxf_store.sv
module rxf_store #(
    parameter int DEPTH   = 4,
    parameter int FRAME_W = 8,
    localparam int PTR_W  = $clog2(DEPTH)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               push,
    input  logic [FRAME_W-1:0] push_data,
    input  logic [1:0]         pop_cnt,
    output logic [FRAME_W-1:0] head0,
    output logic [FRAME_W-1:0] head1
);
    logic [PTR_W-1:0]   wr_ptr_q;
    logic [PTR_W-1:0]   rd_ptr_q;
    logic [PTR_W-1:0]   rd_ptr_nx;
    logic [FRAME_W-1:0] slot_q [DEPTH];

    // one register per entry, each with its own write enable
    for (genvar gi = 0; gi < DEPTH; gi++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                slot_q[gi] <= '0;
            end else if (push && (wr_ptr_q == PTR_W'(gi))) begin
                slot_q[gi] <= push_data;
            end
        end
    end

    assign rd_ptr_nx = rd_ptr_q + PTR_W'(1);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
        end else begin
            if (push) begin
                wr_ptr_q <= wr_ptr_q + PTR_W'(1);
            end
            rd_ptr_q <= rd_ptr_q + PTR_W'(pop_cnt);
        end
    end

    assign head0 = slot_q[rd_ptr_q];
    assign head1 = slot_q[rd_ptr_nx];
endmodule

// File: rtl/rxf_fill_fsm.sv
module rxf_fill_fsm
    import rxf_pkg::*;
#(
    parameter int DEPTH  = 4,
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [1:0]       pop_cnt,
    input  logic             thresh16,
    output logic [LVL_W-1:0] level,
    output logic             rxne
);
    logic [LVL_W-1:0] level_q;
    logic [LVL_W-1:0] level_d;
    fill_e            state_q;
    fill_e            state_d;

    assign level_d = level_q + LVL_W'(push) - LVL_W'(pop_cnt);

    // next fill class from the next level (GO_EMPTY / GO_SINGLE / GO_PAIR / GO_FULL / HOLD)
    always_comb begin
        if (level_d == '0) begin
            state_d = FILL_EMPTY;
        end else if (level_d == LVL_W'(1)) begin
            state_d = FILL_SINGLE;
        end else if (level_d == LVL_W'(DEPTH)) begin
            state_d = FILL_FULL;
        end else begin
            state_d = FILL_PAIR;
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= FILL_EMPTY;
            level_q <= '0;
        end else begin
            state_q <= state_d;
            level_q <= level_d;
        end
    end

    // outputs from the current state
    always_comb begin
        unique case (state_q)
            FILL_EMPTY:  rxne = 1'b0;
            FILL_SINGLE: rxne = !thresh16;
            FILL_PAIR:   rxne = 1'b1;
            FILL_FULL:   rxne = 1'b1;
        endcase
    end

    assign level = level_q;
endmodule

// File: rtl/spi_rx_pack_fifo.sv
module spi_rx_pack_fifo #(
    parameter int DEPTH   = 4,
    parameter int FRAME_W = 8,
    localparam int LVL_W  = $clog2(DEPTH + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_valid,
    input  logic [FRAME_W-1:0]   wr_data,
    input  logic                 rd_en,
    input  logic                 rd_half,
    input  logic                 thresh16,
    input  logic                 ovr_clr,
    output logic [2*FRAME_W-1:0] rd_data,
    output logic                 rxne,
    output logic                 ovr,
    output logic [LVL_W-1:0]     level
);
    logic [1:0]         pop_cnt;
    logic               has_one;
    logic               has_two;
    logic               room;
    logic               push;
    logic               drop;
    logic               ovr_q;
    logic [FRAME_W-1:0] head0;
    logic [FRAME_W-1:0] head1;
    logic [LVL_W-1:0]   level_w;

    assign has_one = (level_w != '0);
    assign has_two = (level_w >= LVL_W'(2));

    // entries removed this cycle: never more than are stored
    always_comb begin
        pop_cnt = 2'd0;
        if (rd_en) begin
            if (rd_half && has_two) begin
                pop_cnt = 2'd2;
            end else if (has_one) begin
                pop_cnt = 2'd1;
            end
        end
    end

    assign room = (level_w - LVL_W'(pop_cnt)) < LVL_W'(DEPTH);
    assign push = wr_valid && room;
    assign drop = wr_valid && !room;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovr_q <= 1'b0;
        end else if (drop) begin
            ovr_q <= 1'b1;
        end else if (ovr_clr) begin
            ovr_q <= 1'b0;
        end
    end

    rxf_store #(
        .DEPTH   (DEPTH),
        .FRAME_W (FRAME_W)
    ) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push),
        .push_data (wr_data),
        .pop_cnt   (pop_cnt),
        .head0     (head0),
        .head1     (head1)
    );

    rxf_fill_fsm #(
        .DEPTH (DEPTH)
    ) u_fill (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (push),
        .pop_cnt  (pop_cnt),
        .thresh16 (thresh16),
        .level    (level_w),
        .rxne     (rxne)
    );

    assign rd_data[FRAME_W-1:0]         = has_one ? head0 : '0;
    assign rd_data[2*FRAME_W-1:FRAME_W] = (rd_half && has_two) ? head1 : '0;
    assign ovr   = ovr_q;
    assign level = level_w;
endmodule

// File: rtl/rxf_checker.sv
module rxf_checker #(
    parameter int DEPTH = 4,
    parameter int LVL_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_valid,
    input logic             rd_en,
    input logic             rd_half,
    input logic             thresh16,
    input logic             ovr_clr,
    input logic             rxne,
    input logic             ovr,
    input logic [LVL_W-1:0] level
);
    assert_level_bounded_R4: assert property (@(posedge clk) disable iff (!rst_n)
        level <= LVL_W'(DEPTH));

    assert_byte_ready_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !thresh16 |-> (rxne == (level != '0)));

    assert_no_false_pair_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (thresh16 && rxne) |-> (level >= LVL_W'(2)));

    assert_packed_from_three_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_half && !wr_valid && level == LVL_W'(3)) |=> (level == LVL_W'(1)));

    assert_empty_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !wr_valid && level == '0) |=> (level == '0));

    assert_net_update_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !rd_half && wr_valid && level != '0) |=> $stable(level));

    assert_full_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !rd_en && level == LVL_W'(DEPTH)) |=> (ovr && level == LVL_W'(DEPTH)));

    assert_ovr_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr && !ovr_clr) |=> ovr);
endmodule

bind spi_rx_pack_fifo rxf_checker #(
    .DEPTH (DEPTH),
    .LVL_W (LVL_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_valid (wr_valid),
    .rd_en    (rd_en),
    .rd_half  (rd_half),
    .thresh16 (thresh16),
    .ovr_clr  (ovr_clr),
    .rxne     (rxne),
    .ovr      (ovr),
    .level    (level)
);

// File: tb/tb_spi_rx_pack_fifo.sv
module tb_spi_rx_pack_fifo;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_valid = 1'b0;
    logic [7:0]  wr_data = '0;
    logic        rd_en = 1'b0;
    logic        rd_half = 1'b0;
    logic        thresh16 = 1'b0;
    logic        ovr_clr = 1'b0;
    logic [15:0] rd_data;
    logic        rxne;
    logic        ovr;
    logic [2:0]  level;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    spi_rx_pack_fifo dut (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_data(wr_data),
        .rd_en(rd_en), .rd_half(rd_half), .thresh16(thresh16), .ovr_clr(ovr_clr),
        .rd_data(rd_data), .rxne(rxne), .ovr(ovr), .level(level)
    );

    typedef struct packed {
        logic        wv;
        logic [7:0]  wd;
        logic        re;
        logic        rh;
        logic        t16;
        logic        clr;
        logic [15:0] x_data;
        logic [2:0]  x_lvl;
        logic        x_rxne;
        logic        x_ovr;
    } vec_t;

    localparam int NV = 25;
    // wv wd re rh t16 clr | rd_data before edge | level rxne ovr after edge
    localparam vec_t VEC [NV] = '{
        '{1'b1, 8'hA1, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0000, 3'd1, 1'b1, 1'b0}, // R2 R5
        '{1'b1, 8'hB2, 1'b0, 1'b0, 1'b1, 1'b0, 16'h00A1, 3'd2, 1'b1, 1'b0}, // R6
        '{1'b1, 8'hC3, 1'b0, 1'b0, 1'b1, 1'b0, 16'h00A1, 3'd3, 1'b1, 1'b0}, // R4
        '{1'b0, 8'h00, 1'b1, 1'b1, 1'b1, 1'b0, 16'hB2A1, 3'd1, 1'b0, 1'b0}, // R3 R6 3/4 -> 1/4
        '{1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 16'h00C3, 3'd1, 1'b1, 1'b0}, // R5
        '{1'b0, 8'h00, 1'b1, 1'b1, 1'b1, 1'b0, 16'h00C3, 3'd0, 1'b0, 1'b0}, // R7 single
        '{1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 16'h0000, 3'd0, 1'b0, 1'b0}, // R7 empty
        '{1'b1, 8'h05, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0000, 3'd1, 1'b1, 1'b0}, // R2 short frame
        '{1'b1, 8'h0A, 1'b1, 1'b0, 1'b0, 1'b0, 16'h0005, 3'd1, 1'b1, 1'b0}, // R8
        '{1'b1, 8'h0B, 1'b0, 1'b0, 1'b0, 1'b0, 16'h000A, 3'd2, 1'b1, 1'b0},
        '{1'b1, 8'h0C, 1'b0, 1'b0, 1'b0, 1'b0, 16'h000A, 3'd3, 1'b1, 1'b0},
        '{1'b1, 8'h0D, 1'b0, 1'b0, 1'b0, 1'b0, 16'h000A, 3'd4, 1'b1, 1'b0}, // R4 full
        '{1'b1, 8'hEE, 1'b0, 1'b0, 1'b0, 1'b0, 16'h000A, 3'd4, 1'b1, 1'b1}, // R9
        '{1'b1, 8'h0F, 1'b1, 1'b1, 1'b1, 1'b0, 16'h0B0A, 3'd3, 1'b1, 1'b1}, // R8 R10
        '{1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 1'b1, 16'h000C, 3'd2, 1'b1, 1'b0}, // R10 clear
        '{1'b0, 8'h00, 1'b1, 1'b1, 1'b1, 1'b0, 16'h0F0D, 3'd0, 1'b0, 1'b0}, // R9 EE gone
        '{1'b1, 8'h11, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0000, 3'd1, 1'b1, 1'b0},
        '{1'b1, 8'h22, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0011, 3'd2, 1'b1, 1'b0},
        '{1'b1, 8'h33, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0011, 3'd3, 1'b1, 1'b0},
        '{1'b1, 8'h44, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0011, 3'd4, 1'b1, 1'b0},
        '{1'b1, 8'h55, 1'b0, 1'b0, 1'b0, 1'b1, 16'h0011, 3'd4, 1'b1, 1'b1}, // R10 set wins
        '{1'b1, 8'h66, 1'b1, 1'b0, 1'b0, 1'b0, 16'h0011, 3'd4, 1'b1, 1'b1}, // R8 full+read
        '{1'b0, 8'h00, 1'b1, 1'b1, 1'b1, 1'b0, 16'h3322, 3'd2, 1'b1, 1'b1}, // R3
        '{1'b0, 8'h00, 1'b1, 1'b1, 1'b1, 1'b0, 16'h6644, 3'd0, 1'b0, 1'b1}, // R3 R9
        '{1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 16'h0000, 3'd0, 1'b0, 1'b0}  // R10
    };

    task automatic chk(input string req, input string what, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic idle_inputs();
        wr_valid = 1'b0; wr_data = '0; rd_en = 1'b0;
        rd_half = 1'b0; thresh16 = 1'b0; ovr_clr = 1'b0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #2;
        // R1: reset state
        chk("R1", "level", 16'(level), 16'h0);
        chk("R1", "rxne", 16'(rxne), 16'h0);
        chk("R1", "ovr", 16'(ovr), 16'h0);
        chk("R1", "rd_data", rd_data, 16'h0000);
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            wr_valid = VEC[i].wv;  wr_data = VEC[i].wd;
            rd_en    = VEC[i].re;  rd_half = VEC[i].rh;
            thresh16 = VEC[i].t16; ovr_clr = VEC[i].clr;
            #2;
            chk("R2/R3/R7 vec", "rd_data", rd_data, VEC[i].x_data);
            @(posedge clk);
            #2;
            chk("R4/R8 vec", "level", 16'(level), 16'(VEC[i].x_lvl));
            chk("R5/R6 vec", "rxne", 16'(rxne), 16'(VEC[i].x_rxne));
            chk("R9/R10 vec", "ovr", 16'(ovr), 16'(VEC[i].x_ovr));
        end

        // directed: fill to full with overrun, then reset mid-run (R1)
        @(negedge clk);
        idle_inputs();
        for (int k = 0; k < 5; k++) begin
            wr_valid = 1'b1; wr_data = 8'(8'h70 + k);
            @(negedge clk);
        end
        idle_inputs();
        #2;
        chk("R9", "level full", 16'(level), 16'h4);
        chk("R9", "ovr", 16'(ovr), 16'h1);
        rst_n = 1'b0;
        @(posedge clk);
        #2;
        chk("R1", "level after reset", 16'(level), 16'h0);
        chk("R1", "ovr after reset", 16'(ovr), 16'h0);
        chk("R1", "rxne after reset", 16'(rxne), 16'h0);
        @(negedge clk);
        rst_n = 1'b1;

        // directed: 16-bit threshold with exactly one then two frames (R6)
        thresh16 = 1'b1;
        wr_valid = 1'b1; wr_data = 8'h09;
        @(negedge clk);
        wr_valid = 1'b0;
        #2;
        chk("R6", "rxne one frame", 16'(rxne), 16'h0);
        wr_valid = 1'b1; wr_data = 8'h06;
        @(negedge clk);
        wr_valid = 1'b0;
        rd_half = 1'b1;
        #2;
        chk("R6", "rxne two frames", 16'(rxne), 16'h1);
        chk("R3", "packed short frames", rd_data, 16'h0609);
        idle_inputs();

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule